// File: doc/BRIEF.md
# Serial Configuration Header Receiver

This block sits at the bit-serial input of a configuration port. On each rising edge of the configuration clock it takes one bit from `din`. It skips any bits until it finds a four-bit start marker, `0010`. It then loads the 24-bit length field that follows, most significant bit first, and passes over 12 pad bits. A running counter counts every bit taken since reset. This includes the bits before the marker and the header itself. When that count reaches the loaded length, the block reports a length match.

The block enables startup only when two events occur in a fixed order. First, memory full must have been seen on `mem_full`. Second, the length match must occur. If the match arrives before memory full, the block enters a fault state and raises an ordering-error flag. Every incoming bit is also passed to `dout` so that downstream receivers can be daisy-chained. `dout` changes on a falling clock edge, one and a half clock periods after the bit was sampled.

The controller has these states:

- ST_HUNT searches for the marker. It moves to ST_LENGTH on the bit that completes `0010`.
- ST_LENGTH shifts in the length field. It moves to ST_PAD after the last length bit.
- ST_PAD skips the pad bits. It moves to ST_PAYLOAD after the last pad bit.
- ST_PAD and ST_PAYLOAD both leave on a length match. They go to ST_GO if memory full has been seen, and to ST_ORDER_FAULT if it has not.
- ST_GO and ST_ORDER_FAULT hold until reset.

Top module: `cfg_stream_hdr`

## Requirements
- R1: Synchronous active-high `rst` clears the bit counter, the captured length, the marker search history and all flags. After reset, `length_match`, `start_ok` and `order_err` are 0, and `dout` is 1.
- R2: Bits that arrive before the marker are never loaded as length bits, but each one is counted.
- R3: Only the exact four-bit run `0010`, first bit first, starts the length field. Lead-in runs such as `0110` and `0011` do not.
- R4: The 24 bits right after the marker form the length, first bit most significant. The next 12 bits are pad and are not loaded.
- R5: Counting the first bit after reset as 1, `length_match` rises right after the rising edge that samples bit number N, where N equals the length. This holds when that edge falls after the last length bit.
- R6: `length_match` stays high until reset.
- R7: If `mem_full` was high on any rising edge up to and including the match edge, `start_ok` rises together with `length_match` and stays high. `order_err` stays 0.
- R8: If `mem_full` was low on every edge up to and including the match edge, `order_err` rises together with `length_match` and `start_ok` stays 0. Both hold even if `mem_full` rises later.
- R9: Each bit sampled on a rising edge appears on `dout` from the falling edge that follows the next rising edge. The bit sampled two rising edges earlier is therefore on `dout` at every rising edge.
- R10: A length no greater than the bit count at the end of the length field never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; data sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial configuration data |
| mem_full | input | 1 | Configuration memory full indication |
| dout | output | 1 | Daisy-chain data, updated on falling edge |
| length_match | output | 1 | Bit count reached captured length |
| start_ok | output | 1 | Memory full then length match, in order |
| order_err | output | 1 | Length match came before memory full |

## Verification
The bench builds the block with its default parameters: a 24-bit length, a four-bit `0010` marker and 12 pad bits. With these values, lengths of 20 to 150 bits cover every case. Matches fall in the pad field, at its last pad bit and in the payload. Lead-in runs exercise the marker search. `mem_full` is raised before the match, on the match edge itself, and after it.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    typedef enum logic [2:0] {
        ST_HUNT        = 3'd0,
        ST_LENGTH      = 3'd1,
        ST_PAD         = 3'd2,
        ST_PAYLOAD     = 3'd3,
        ST_GO          = 3'd4,
        ST_ORDER_FAULT = 3'd5
    } hdr_state_e;

endpackage

// File: rtl/cfghdr_sync_hunt.sv
// Marker detector: compares the last SYNC_W-1 history bits plus the live bit.
module cfghdr_sync_hunt #(
    parameter int                SYNC_W   = 4,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 4'b0010
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic hit
);
    localparam int HIST_W = SYNC_W - 1;

    logic [HIST_W-1:0] hist_q;

    // History resets to all ones so a pattern starting with 0 cannot match early.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
        end else if (en) begin
            hist_q <= {hist_q[HIST_W-2:0], din};
        end
    end

    assign hit = en && ({hist_q, din} == SYNC_PAT);

endmodule

// File: rtl/cfghdr_len_track.sv
// Bit counter, length shift register and equality compare.
module cfghdr_len_track #(
    parameter int LEN_W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    input  logic shift_en,
    input  logic cmp_en,
    input  logic din,
    output logic hit
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_next;

    assign cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= '0;
        end else begin
            if (count_en) begin
                cnt_q <= cnt_next;
            end
            if (shift_en) begin
                len_q <= {len_q[LEN_W-2:0], din};
            end
        end
    end

    // Compare against the count that includes the bit sampled on this edge.
    assign hit = cmp_en && (cnt_next == len_q);

endmodule

// File: rtl/cfghdr_chain_out.sv
// Pass-through: two rising-edge stages, then a falling-edge output stage.
module cfghdr_chain_out (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic stg1_q;
    logic stg2_q;
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1_q <= 1'b1;
            stg2_q <= 1'b1;
        end else begin
            stg1_q <= din;
            stg2_q <= stg1_q;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            out_q <= 1'b1;
        end else begin
            out_q <= stg2_q;
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/cfg_stream_hdr.sv
module cfg_stream_hdr #(
    parameter int                LEN_W    = 24,
    parameter int                SYNC_W   = 4,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 4'b0010,
    parameter int                PAD_BITS = 12
) (
    input  logic cclk,
    input  logic rst,
    input  logic din,
    input  logic mem_full,
    output logic dout,
    output logic length_match,
    output logic start_ok,
    output logic order_err
);
    import cfg_hdr_pkg::*;

    localparam int FLD_MAX = (LEN_W > PAD_BITS) ? LEN_W : PAD_BITS;
    localparam int FLD_W   = $clog2(FLD_MAX + 1);
    localparam logic [FLD_W-1:0] LEN_LAST = FLD_W'(LEN_W - 1);
    localparam logic [FLD_W-1:0] PAD_LAST = FLD_W'((PAD_BITS > 0) ? PAD_BITS - 1 : 0);

    hdr_state_e       state_q, state_d;
    logic [FLD_W-1:0] fld_q, fld_d;
    logic             full_seen_q;
    logic             full_now;
    logic             sync_hit;
    logic             len_hit;
    logic             terminal;

    assign terminal = (state_q == ST_GO) || (state_q == ST_ORDER_FAULT);
    assign full_now = full_seen_q || mem_full;

    cfghdr_sync_hunt #(
        .SYNC_W   (SYNC_W),
        .SYNC_PAT (SYNC_PAT)
    ) hunt_i (
        .clk (cclk),
        .rst (rst),
        .en  (state_q == ST_HUNT),
        .din (din),
        .hit (sync_hit)
    );

    cfghdr_len_track #(
        .LEN_W (LEN_W)
    ) track_i (
        .clk      (cclk),
        .rst      (rst),
        .count_en (!terminal),
        .shift_en (state_q == ST_LENGTH),
        .cmp_en   ((state_q == ST_PAD) || (state_q == ST_PAYLOAD)),
        .din      (din),
        .hit      (len_hit)
    );

    cfghdr_chain_out chain_i (
        .clk  (cclk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    // Sticky record of memory full.
    always_ff @(posedge cclk) begin
        if (rst) begin
            full_seen_q <= 1'b0;
        end else if (mem_full) begin
            full_seen_q <= 1'b1;
        end
    end

    // State register.
    always_ff @(posedge cclk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            fld_q   <= '0;
        end else begin
            state_q <= state_d;
            fld_q   <= fld_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        fld_d   = fld_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sync_hit) begin
                    state_d = ST_LENGTH;
                    fld_d   = '0;
                end
            end
            ST_LENGTH: begin
                if (fld_q == LEN_LAST) begin
                    fld_d   = '0;
                    state_d = (PAD_BITS == 0) ? ST_PAYLOAD : ST_PAD;
                end else begin
                    fld_d = fld_q + 1'b1;
                end
            end
            ST_PAD: begin
                if (len_hit) begin
                    state_d = full_now ? ST_GO : ST_ORDER_FAULT;
                end else if (fld_q == PAD_LAST) begin
                    state_d = ST_PAYLOAD;
                    fld_d   = '0;
                end else begin
                    fld_d = fld_q + 1'b1;
                end
            end
            ST_PAYLOAD: begin
                if (len_hit) begin
                    state_d = full_now ? ST_GO : ST_ORDER_FAULT;
                end
            end
            ST_GO, ST_ORDER_FAULT: begin
                state_d = state_q;
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        length_match = terminal;
        start_ok     = (state_q == ST_GO);
        order_err    = (state_q == ST_ORDER_FAULT);
    end

endmodule

// File: rtl/cfghdr_chk.sv
module cfghdr_chk (
    input logic cclk,
    input logic rst,
    input logic din,
    input logic mem_full,
    input logic dout,
    input logic length_match,
    input logic start_ok,
    input logic order_err,
    input logic full_seen_q
);
    logic [1:0] warm_q;

    always_ff @(posedge cclk) begin
        if (rst) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge cclk) disable iff (rst)
        $past(rst) |-> (!length_match && !start_ok && !order_err && dout));

    assert_match_sticky_R6: assert property (@(posedge cclk) disable iff (rst)
        length_match |=> length_match);

    assert_go_after_full_R7: assert property (@(posedge cclk) disable iff (rst)
        $rose(start_ok) |-> ($past(full_seen_q) || $past(mem_full)));

    assert_go_with_match_R7: assert property (@(posedge cclk) disable iff (rst)
        start_ok |-> (length_match && !order_err));

    assert_fault_no_full_R8: assert property (@(posedge cclk) disable iff (rst)
        $rose(order_err) |-> (!$past(full_seen_q) && !$past(mem_full)));

    assert_fault_holds_R8: assert property (@(posedge cclk) disable iff (rst)
        order_err |=> (order_err && !start_ok));

    assert_chain_delay_R9: assert property (@(posedge cclk) disable iff (rst)
        (warm_q >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

bind cfg_stream_hdr cfghdr_chk chk_i (.*);

// File: tb/cfg_stream_hdr_tb_top.sv
`timescale 1ns/1ps
module cfg_stream_hdr_tb_top;

    logic cclk = 1'b0;
    logic rst  = 1'b1;
    logic din  = 1'b1;
    logic mem_full = 1'b0;
    logic dout, length_match, start_ok, order_err;

    int tests_run = 0;
    int tests_failed = 0;
    int nbits = 0;
    logic sent [0:1023];

    always #2 cclk = ~cclk;   // 250 MHz

    cfg_stream_hdr dut_i (
        .cclk         (cclk),
        .rst          (rst),
        .din          (din),
        .mem_full     (mem_full),
        .dout         (dout),
        .length_match (length_match),
        .start_ok     (start_ok),
        .order_err    (order_err)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s bit=%0d actual=%b expected=%b", req, what, nbits, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge cclk);
        rst = 1'b1; din = 1'b1; mem_full = 1'b0;
        repeat (3) @(posedge cclk);
        #1 rst = 1'b0;
        nbits = 0;
        check("R1", "length_match", length_match, 1'b0);
        check("R1", "start_ok",     start_ok,     1'b0);
        check("R1", "order_err",    order_err,    1'b0);
        check("R1", "dout",         dout,         1'b1);
    endtask

    task automatic send_bit(input logic b, input int full_bit);
        @(negedge cclk);
        din = b;
        mem_full = ((nbits + 1) >= full_bit);
        @(posedge cclk);
        #1;
        nbits++;
        sent[nbits] = b;
    endtask

    task automatic check_bit(input string req, input int lead_n, input logic [23:0] len, input int full_bit);
        logic ex_m, ex_s, ex_e, ex_d;
        ex_m = (int'(len) >= lead_n + 29) && (nbits >= int'(len));
        ex_s = ex_m && (full_bit <= int'(len));
        ex_e = ex_m && (full_bit >  int'(len));
        ex_d = (nbits <= 2) ? 1'b1 : sent[nbits-2];
        check(req,  "length_match", length_match, ex_m);
        check("R7", "start_ok",     start_ok,     ex_s);
        check("R8", "order_err",    order_err,    ex_e);
        check("R9", "dout",         dout,         ex_d);
    endtask

    // Lead-in bits (first bit = lead_vec[lead_n-1]), marker, length, pad, payload.
    task automatic run_case(input string req, input logic [15:0] lead_vec, input int lead_n,
                            input logic [23:0] len, input int full_bit, input int total);
        do_reset();
        for (int i = lead_n - 1; i >= 0; i--) begin
            send_bit(lead_vec[i], full_bit);
            check_bit(req, lead_n, len, full_bit);
        end
        for (int i = 3; i >= 0; i--) begin
            send_bit(logic'((4'b0010 >> i) & 1), full_bit);
            check_bit(req, lead_n, len, full_bit);
        end
        for (int i = 23; i >= 0; i--) begin
            send_bit(len[i], full_bit);
            check_bit(req, lead_n, len, full_bit);
        end
        while (nbits < total) begin
            send_bit(logic'(nbits % 3 == 0), full_bit);
            check_bit(req, lead_n, len, full_bit);
        end
    endtask

    initial begin
        repeat (100000) @(posedge cclk);
        tests_failed++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        // R5: no lead-in, match inside payload, memory full earlier (R7)
        run_case("R5", 16'h0, 0, 24'd60, 50, 75);
        // R2: seven lead-in ones are counted; R6 sticky past the match
        run_case("R2", 16'h7F, 7, 24'd80, 10, 100);
        // R3: lead-in 0110011 holds near-miss runs
        run_case("R3", 16'b0110011, 7, 24'd70, 5, 85);
        // R8: match before memory full, which rises later
        run_case("R8", 16'h0, 0, 24'd50, 60, 80);
        // R10: length shorter than the header never matches
        run_case("R10", 16'h0, 0, 24'd20, 1, 60);
        // R4: MSB-first value 0x000093 = 147
        run_case("R4", 16'h3, 2, 24'h000093, 100, 155);
        // R7: memory full on the match edge itself, match on the last pad bit (R4)
        run_case("R7", 16'h1, 1, 24'd41, 41, 55);
        // R1: reset after a completed run clears everything
        do_reset();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule